// File: doc/BRIEF.md
# Cache-Block Operation Access Gate

This combinational unit decides whether a cache-block management operation (clean, flush, invalidate or zero a block) may execute at the current privilege level. It reads the privilege level, a virtualization flag, the per-operation enable fields held by the machine, supervisor and hypervisor environment-configuration registers, and two flags that say which operation families are implemented. It returns one verdict: allow, illegal-instruction trap or virtual-instruction trap.

When the verdict is allow, the unit also drives the actions the memory side must perform. An invalidate request can be upgraded to clean-plus-invalidate when a less privileged level is configured for flush mode. A separate path renames load-type fault causes raised while such an operation runs into the matching store-type causes. The configuration registers and the memory access are outside the block.

Top module: `cmo_access_gate`

## Requirements
- R1: Encodings used throughout: verdict 00 = allow, 01 = illegal-instruction trap, 10 = virtual-instruction trap (11 is never produced); op 00 = clean, 01 = flush, 10 = invalidate, 11 = zero; privilege 00 = user, 01 = supervisor, 11 = machine, and 10 is treated as supervisor.
- R2: If the family of the requested op is not implemented (`ext_mgmt` for clean, flush and invalidate, `ext_zero` for zero), the verdict is illegal at every privilege level, and the fields of that family act as zero.
- R3: At supervisor or user level, a disabled machine-level field gives an illegal verdict.
- R4: At user level with virtualization off, a disabled supervisor-level field gives an illegal verdict.
- R5: With virtualization on below machine level, a disabled hypervisor-level field, or user level with a disabled supervisor-level field, gives a virtual verdict; every illegal condition takes priority over it.
- R6: At machine level the verdict is allow whenever the family is implemented, whatever the fields and the virtualization flag.
- R7: Clean and flush are governed only by the one-bit clean enable, invalidate only by the two-bit invalidate control, zero only by the one-bit zero enable; a field belonging to another op has no effect on the verdict or actions.
- R8: The two-bit invalidate control reads 00 = disabled, 01 = enabled in flush mode, 11 = enabled as true invalidate, 10 = disabled.
- R9: An allowed invalidate performs clean plus invalidate when any governing level's control is 01 (supervisor: machine; user: machine, supervisor; virtual supervisor: machine, hypervisor; virtual user: all three; machine: none); otherwise it invalidates without cleaning.
- R10: On allow, clean drives only `do_clean`, flush drives `do_clean` and `do_inval`, zero drives only `do_zero`; on any trap all three are 0.
- R11: A fault cause of 4, 5, 13 or 21 (load misaligned, access, page, guest page) appears on `fault_cause_out` as 6, 7, 15 or 23; every other cause passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization mode flag |
| op | input | 2 | Requested cache-block operation |
| ext_mgmt | input | 1 | Clean/flush/invalidate family implemented |
| ext_zero | input | 1 | Zero family implemented |
| m_clean_en | input | 1 | Machine-level clean/flush enable |
| m_inval_ctl | input | 2 | Machine-level invalidate control |
| m_zero_en | input | 1 | Machine-level zero enable |
| s_clean_en | input | 1 | Supervisor-level clean/flush enable |
| s_inval_ctl | input | 2 | Supervisor-level invalidate control |
| s_zero_en | input | 1 | Supervisor-level zero enable |
| h_clean_en | input | 1 | Hypervisor-level clean/flush enable |
| h_inval_ctl | input | 2 | Hypervisor-level invalidate control |
| h_zero_en | input | 1 | Hypervisor-level zero enable |
| fault_cause_in | input | CAUSE_W | Fault cause raised by the operation |
| verdict | output | 2 | Allow / illegal / virtual result |
| do_clean | output | 1 | Write back the block if dirty |
| do_inval | output | 1 | Drop the block from the cache |
| do_zero | output | 1 | Write zeros to the whole block |
| fault_cause_out | output | CAUSE_W | Cause reported for the fault |

## Verification
The unit holds no state, so a wrong internal decision shows at the ports in the same evaluation as the inputs that caused it. A mistaken per-level enable or a wrong governing set surfaces as a verdict of the wrong kind, most visibly where illegal and virtual conditions overlap and priority decides the outcome. A wrong flush-mode decision is seen only on `do_clean` for an allowed invalidate, so the bench sweeps every invalidate control at every level against an independent model.

// File: rtl/cmo_gate_pkg.sv
package cmo_gate_pkg;
  localparam int NUM_LVL = 3;
  localparam int LVL_M = 0;
  localparam int LVL_S = 1;
  localparam int LVL_H = 2;

  typedef enum logic [1:0] {
    PRV_USER = 2'b00,
    PRV_SUPV = 2'b01,
    PRV_RSVD = 2'b10,
    PRV_MACH = 2'b11
  } prv_e;

  typedef enum logic [1:0] {
    OP_CLEAN = 2'b00,
    OP_FLUSH = 2'b01,
    OP_INVAL = 2'b10,
    OP_ZERO  = 2'b11
  } cbop_e;

  typedef enum logic [1:0] {
    VERD_ALLOW   = 2'b00,
    VERD_ILLEGAL = 2'b01,
    VERD_VIRTUAL = 2'b10
  } verd_e;

  localparam int CAUSE_LD_MISALIGN = 4;
  localparam int CAUSE_LD_ACCESS   = 5;
  localparam int CAUSE_LD_PAGE     = 13;
  localparam int CAUSE_LD_GPAGE    = 21;
  localparam int CAUSE_LD_TO_ST    = 2;

  function automatic logic is_load_fault(input int unsigned c);
    return (c == CAUSE_LD_MISALIGN) || (c == CAUSE_LD_ACCESS) ||
           (c == CAUSE_LD_PAGE) || (c == CAUSE_LD_GPAGE);
  endfunction

  function automatic logic ctl_enabled(input logic [1:0] ctl);
    return ctl == 2'b01 || ctl == 2'b11;
  endfunction

  function automatic logic ctl_flush_mode(input logic [1:0] ctl);
    return ctl == 2'b01;
  endfunction
endpackage

// File: rtl/cmo_field_select.sv
module cmo_field_select
  import cmo_gate_pkg::*;
#(
  parameter int LVLS = NUM_LVL
) (
  input  cbop_e                 op,
  input  logic                  ext_mgmt,
  input  logic                  ext_zero,
  input  logic [LVLS-1:0]       clean_bits,
  input  logic [LVLS-1:0][1:0]  inval_ctls,
  input  logic [LVLS-1:0]       zero_bits,
  output logic [LVLS-1:0]       lvl_en,
  output logic [LVLS-1:0]       lvl_flush
);
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    logic       clean_eff;
    logic [1:0] inval_eff;
    logic       zero_eff;
    assign clean_eff = clean_bits[l] & ext_mgmt;
    assign inval_eff = inval_ctls[l] & {2{ext_mgmt}};
    assign zero_eff  = zero_bits[l] & ext_zero;
    always_comb begin
      lvl_flush[l] = 1'b0;
      unique case (op)
        OP_CLEAN, OP_FLUSH: lvl_en[l] = clean_eff;
        OP_INVAL: begin
          lvl_en[l]    = ctl_enabled(inval_eff);
          lvl_flush[l] = ctl_flush_mode(inval_eff);
        end
        default: lvl_en[l] = zero_eff;
      endcase
    end
  end
endmodule

// File: rtl/cmo_perm_eval.sv
module cmo_perm_eval
  import cmo_gate_pkg::*;
#(
  parameter int LVLS = NUM_LVL
) (
  input  prv_e             priv,
  input  logic             virt,
  input  logic             family_ok,
  input  logic [LVLS-1:0]  lvl_en,
  input  logic [LVLS-1:0]  lvl_flush,
  output logic             illegal_hit,
  output logic             virtual_hit,
  output logic             upgrade_flush,
  output verd_e            verd
);
  logic below_m, is_user, virt_eff;
  logic [LVLS-1:0] governs;

  assign below_m  = priv != PRV_MACH;
  assign is_user  = priv == PRV_USER;
  assign virt_eff = virt & below_m;

  always_comb begin
    governs        = '0;
    governs[LVL_M] = below_m;
    governs[LVL_S] = is_user;
    governs[LVL_H] = virt_eff;
  end

  assign illegal_hit = !family_ok
                     | (below_m & !lvl_en[LVL_M])
                     | (is_user & !virt_eff & !lvl_en[LVL_S]);
  assign virtual_hit = virt_eff & (!lvl_en[LVL_H] | (is_user & !lvl_en[LVL_S]));
  assign upgrade_flush = |(governs & lvl_flush);

  always_comb begin
    if (illegal_hit)      verd = VERD_ILLEGAL;
    else if (virtual_hit) verd = VERD_VIRTUAL;
    else                  verd = VERD_ALLOW;
  end
endmodule

// File: rtl/cmo_fault_remap.sv
module cmo_fault_remap
  import cmo_gate_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic [CAUSE_W-1:0] cause_in,
  output logic [CAUSE_W-1:0] cause_out
);
  function automatic logic [CAUSE_W-1:0] to_store(input logic [CAUSE_W-1:0] c);
    if (is_load_fault(int'(unsigned'(c))))
      return c + CAUSE_W'(CAUSE_LD_TO_ST);
    return c;
  endfunction

  assign cause_out = to_store(cause_in);
endmodule

// File: rtl/cmo_access_gate.sv
module cmo_access_gate
  import cmo_gate_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [1:0]         op,
  input  logic               ext_mgmt,
  input  logic               ext_zero,
  input  logic               m_clean_en,
  input  logic [1:0]         m_inval_ctl,
  input  logic               m_zero_en,
  input  logic               s_clean_en,
  input  logic [1:0]         s_inval_ctl,
  input  logic               s_zero_en,
  input  logic               h_clean_en,
  input  logic [1:0]         h_inval_ctl,
  input  logic               h_zero_en,
  input  logic [CAUSE_W-1:0] fault_cause_in,
  output logic [1:0]         verdict,
  output logic               do_clean,
  output logic               do_inval,
  output logic               do_zero,
  output logic [CAUSE_W-1:0] fault_cause_out
);
  cbop_e op_e;
  prv_e  priv_e;
  verd_e verd;
  logic  family_ok, allow;
  logic  illegal_hit, virtual_hit, upgrade_flush;
  logic [NUM_LVL-1:0]      clean_bits, zero_bits, lvl_en, lvl_flush;
  logic [NUM_LVL-1:0][1:0] inval_ctls;

  assign op_e   = cbop_e'(op);
  assign priv_e = prv_e'(priv);
  assign family_ok = (op_e == OP_ZERO) ? ext_zero : ext_mgmt;

  always_comb begin
    clean_bits[LVL_M] = m_clean_en;  inval_ctls[LVL_M] = m_inval_ctl;  zero_bits[LVL_M] = m_zero_en;
    clean_bits[LVL_S] = s_clean_en;  inval_ctls[LVL_S] = s_inval_ctl;  zero_bits[LVL_S] = s_zero_en;
    clean_bits[LVL_H] = h_clean_en;  inval_ctls[LVL_H] = h_inval_ctl;  zero_bits[LVL_H] = h_zero_en;
  end

  cmo_field_select #(.LVLS(NUM_LVL)) u_sel (
    .op(op_e), .ext_mgmt(ext_mgmt), .ext_zero(ext_zero),
    .clean_bits(clean_bits), .inval_ctls(inval_ctls), .zero_bits(zero_bits),
    .lvl_en(lvl_en), .lvl_flush(lvl_flush)
  );

  cmo_perm_eval #(.LVLS(NUM_LVL)) u_eval (
    .priv(priv_e), .virt(virt), .family_ok(family_ok),
    .lvl_en(lvl_en), .lvl_flush(lvl_flush),
    .illegal_hit(illegal_hit), .virtual_hit(virtual_hit),
    .upgrade_flush(upgrade_flush), .verd(verd)
  );

  cmo_fault_remap #(.CAUSE_W(CAUSE_W)) u_fault (
    .cause_in(fault_cause_in), .cause_out(fault_cause_out)
  );

  assign verdict = verd;
  assign allow   = verd == VERD_ALLOW;

  always_comb begin
    do_clean = 1'b0;
    do_inval = 1'b0;
    do_zero  = 1'b0;
    if (allow) begin
      unique case (op_e)
        OP_CLEAN: do_clean = 1'b1;
        OP_FLUSH: begin do_clean = 1'b1; do_inval = 1'b1; end
        OP_INVAL: begin do_clean = upgrade_flush; do_inval = 1'b1; end
        default:  do_zero = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cmo_access_gate_checks.sv
module cmo_access_gate_checks
  import cmo_gate_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input logic [1:0]         priv,
  input logic [1:0]         op,
  input logic               ext_mgmt,
  input logic               ext_zero,
  input logic               illegal_hit,
  input logic               virtual_hit,
  input logic               upgrade_flush,
  input logic [1:0]         verdict,
  input logic               do_clean,
  input logic               do_inval,
  input logic               do_zero,
  input logic [CAUSE_W-1:0] fault_cause_out
);
  logic fam_ok;
  assign fam_ok = (op == 2'b11) ? ext_zero : ext_mgmt;

  always_comb begin
    AST_VERDICT_CODE: assert (verdict != 2'b11); // R1
    AST_NO_FAMILY_TRAPS: assert (fam_ok || verdict == 2'b01); // R2
    AST_ILLEGAL_WINS: assert (!illegal_hit || verdict == 2'b01); // R5
    AST_VIRTUAL_SEEN: assert (!(virtual_hit && !illegal_hit) || verdict == 2'b10); // R5
    AST_MACHINE_FREE: assert (!(priv == 2'b11 && fam_ok) || verdict == 2'b00); // R6
    AST_QUIET_ON_TRAP: assert (verdict == 2'b00 || !(do_clean || do_inval || do_zero)); // R10
    AST_ONE_ACTION_KIND: assert (!(do_zero && (do_clean || do_inval))); // R10
    AST_INVAL_UPGRADE: assert (!(verdict == 2'b00 && op == 2'b10) || (do_inval && do_clean == upgrade_flush)); // R9
    AST_NO_LOAD_CAUSE: assert (!is_load_fault(int'(unsigned'(fault_cause_out)))); // R11
  end
endmodule

bind cmo_access_gate cmo_access_gate_checks #(.CAUSE_W(CAUSE_W)) u_checks (
  .priv(priv), .op(op), .ext_mgmt(ext_mgmt), .ext_zero(ext_zero),
  .illegal_hit(illegal_hit), .virtual_hit(virtual_hit), .upgrade_flush(upgrade_flush),
  .verdict(verdict), .do_clean(do_clean), .do_inval(do_inval), .do_zero(do_zero),
  .fault_cause_out(fault_cause_out)
);

// File: tb/cmo_access_gate_test.sv
module cmo_access_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] priv, op, m_ic, s_ic, h_ic, verdict;
  logic virt, ext_mgmt, ext_zero;
  logic m_ce, m_ze, s_ce, s_ze, h_ce, h_ze;
  logic do_clean, do_inval, do_zero;
  logic [CW-1:0] fc_in, fc_out;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  cmo_access_gate #(.CAUSE_W(CW)) uut (
    .priv(priv), .virt(virt), .op(op), .ext_mgmt(ext_mgmt), .ext_zero(ext_zero),
    .m_clean_en(m_ce), .m_inval_ctl(m_ic), .m_zero_en(m_ze),
    .s_clean_en(s_ce), .s_inval_ctl(s_ic), .s_zero_en(s_ze),
    .h_clean_en(h_ce), .h_inval_ctl(h_ic), .h_zero_en(h_ze),
    .fault_cause_in(fc_in), .verdict(verdict),
    .do_clean(do_clean), .do_inval(do_inval), .do_zero(do_zero),
    .fault_cause_out(fc_out)
  );

  // config nibble per level: {zero, inval_ctl[1:0], clean}
  task automatic drive(input logic [1:0] p, input logic v, input logic [1:0] o,
                       input logic em, input logic ez,
                       input logic [3:0] mc, input logic [3:0] sc, input logic [3:0] hc);
    priv = p; virt = v; op = o; ext_mgmt = em; ext_zero = ez;
    {m_ze, m_ic, m_ce} = mc;
    {s_ze, s_ic, s_ce} = sc;
    {h_ze, h_ic, h_ce} = hc;
    #1;
  endtask

  // reference: which of the level nibbles enables this op
  function automatic bit lvl_on(input logic [1:0] o, input logic [3:0] c,
                                input logic em, input logic ez);
    case (o)
      2'b11:   return ez && c[3];
      2'b10:   return em && c[1];
      default: return em && c[0];
    endcase
  endfunction

  function automatic logic [1:0] ref_verdict(input logic [1:0] p, input logic v, input logic [1:0] o,
      input logic em, input logic ez, input logic [3:0] mc, input logic [3:0] sc, input logic [3:0] hc);
    bit fam, user, vv;
    fam  = (o == 2'b11) ? ez : em;
    if (!fam) return 2'b01;
    if (p == 2'b11) return 2'b00;
    user = (p == 2'b00);
    vv   = v;
    if (!lvl_on(o, mc, em, ez)) return 2'b01;
    if (user && !vv && !lvl_on(o, sc, em, ez)) return 2'b01;
    if (vv && !lvl_on(o, hc, em, ez)) return 2'b10;
    if (vv && user && !lvl_on(o, sc, em, ez)) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [2:0] ref_actions(input logic [1:0] p, input logic v, input logic [1:0] o,
      input logic em, input logic ez, input logic [3:0] mc, input logic [3:0] sc, input logic [3:0] hc);
    bit up;
    if (ref_verdict(p, v, o, em, ez, mc, sc, hc) != 2'b00) return 3'b000;
    case (o)
      2'b00: return 3'b100;
      2'b01: return 3'b110;
      2'b11: return 3'b001;
      default: begin
        up = 0;
        if (p != 2'b11) begin
          if (em && mc[2:1] == 2'b01) up = 1;
          if (p == 2'b00 && em && sc[2:1] == 2'b01) up = 1;
          if (v && em && hc[2:1] == 2'b01) up = 1;
        end
        return {up, 2'b10};
      end
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "verdict", int'(verdict),
          int'(ref_verdict(priv, virt, op, ext_mgmt, ext_zero, {m_ze,m_ic,m_ce}, {s_ze,s_ic,s_ce}, {h_ze,h_ic,h_ce})));
    check(req, "actions", int'({do_clean, do_inval, do_zero}),
          int'(ref_actions(priv, virt, op, ext_mgmt, ext_zero, {m_ze,m_ic,m_ce}, {s_ze,s_ic,s_ce}, {h_ze,h_ic,h_ce})));
  endtask

  task automatic t_reset_state();
    drive(2'b01, 0, 2'b00, 1, 1, 4'h0, 4'h0, 4'h0);
    check("R3", "all-zero config supervisor clean", int'(verdict), 1);
    check("R10", "no action on trap", int'({do_clean, do_inval, do_zero}), 0);
  endtask

  task automatic t_missing_family();
    drive(2'b11, 0, 2'b01, 0, 1, 4'hF, 4'hF, 4'hF);
    check("R2", "flush w/o family at M", int'(verdict), 1);
    drive(2'b11, 0, 2'b11, 1, 0, 4'hF, 4'hF, 4'hF);
    check("R2", "zero w/o family at M", int'(verdict), 1);
    drive(2'b01, 0, 2'b11, 0, 1, 4'h8, 4'h0, 4'h0);
    check("R2", "zero works without mgmt family", int'(verdict), 0);
  endtask

  task automatic t_machine_level();
    drive(2'b11, 1, 2'b10, 1, 1, 4'h0, 4'h0, 4'h0);
    check("R6", "M ignores fields and virt", int'(verdict), 0);
    check("R9", "M invalidate is pure", int'({do_clean, do_inval}), 1);
  endtask

  task automatic t_illegal_paths();
    drive(2'b01, 0, 2'b00, 1, 1, 4'h0, 4'h1, 4'h1);
    check("R3", "S with M clean off", int'(verdict), 1);
    drive(2'b00, 0, 2'b00, 1, 1, 4'h1, 4'h0, 4'h1);
    check("R4", "U with S clean off", int'(verdict), 1);
    drive(2'b10, 0, 2'b00, 1, 1, 4'h1, 4'h0, 4'h0);
    check("R1", "reserved priv acts as S", int'(verdict), 0);
  endtask

  task automatic t_virtual_paths();
    drive(2'b01, 1, 2'b00, 1, 1, 4'h1, 4'h1, 4'h0);
    check("R5", "VS with H off", int'(verdict), 2);
    drive(2'b00, 1, 2'b00, 1, 1, 4'h1, 4'h0, 4'h1);
    check("R5", "VU with S off", int'(verdict), 2);
    drive(2'b00, 1, 2'b00, 1, 1, 4'h0, 4'h0, 4'h0);
    check("R5", "illegal beats virtual", int'(verdict), 1);
    drive(2'b00, 1, 2'b01, 1, 1, 4'h1, 4'h1, 4'h1);
    check("R10", "VU flush allowed actions", int'({do_clean, do_inval, do_zero}), 6);
  endtask

  task automatic t_field_isolation();
    drive(2'b01, 0, 2'b11, 1, 1, 4'h7, 4'h7, 4'h7);
    check("R7", "zero ignores clean/inval fields", int'(verdict), 1);
    drive(2'b01, 0, 2'b00, 1, 1, 4'hE, 4'h0, 4'h0);
    check("R7", "clean ignores zero/inval fields", int'(verdict), 1);
    drive(2'b01, 0, 2'b11, 1, 1, 4'h8, 4'h0, 4'h0);
    check("R10", "zero action", int'({do_clean, do_inval, do_zero}), 1);
  endtask

  task automatic t_inval_modes();
    drive(2'b01, 0, 2'b10, 1, 1, 4'h4, 4'h0, 4'h0);
    check("R8", "ctl 10 disabled", int'(verdict), 1);
    drive(2'b01, 0, 2'b10, 1, 1, 4'h6, 4'h0, 4'h0);
    check("R8", "ctl 11 true invalidate", int'({do_clean, do_inval}), 1);
    drive(2'b01, 0, 2'b10, 1, 1, 4'h2, 4'h0, 4'h0);
    check("R9", "ctl 01 upgrades to flush", int'({do_clean, do_inval}), 3);
    drive(2'b00, 1, 2'b10, 1, 1, 4'h6, 4'h6, 4'h2);
    check("R9", "VU hypervisor flush mode", int'({do_clean, do_inval}), 3);
    drive(2'b01, 0, 2'b10, 1, 1, 4'h6, 4'h2, 4'h2);
    check("R9", "S ignores S/H flush mode", int'({do_clean, do_inval}), 1);
  endtask

  task automatic t_faults();
    int src[8] = '{4, 5, 13, 21, 6, 0, 12, 63};
    int exp[8] = '{6, 7, 15, 23, 6, 0, 12, 63};
    for (int i = 0; i < 8; i++) begin
      fc_in = CW'(src[i]);
      #1;
      check("R11", $sformatf("cause %0d", src[i]), int'(fc_out), exp[i]);
    end
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 2; v++)
        for (int o = 0; o < 4; o++)
          for (int e = 0; e < 4; e++)
            for (int c = 0; c < 4096; c += 37) begin
              drive(2'(p), 1'(v), 2'(o), e[0], e[1], c[3:0], c[7:4], c[11:8]);
              check_all("R9 sweep");
            end
  endtask

  initial begin
    fc_in = '0;
    drive(2'b01, 0, 2'b00, 1, 1, 4'h0, 4'h0, 4'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_missing_family();
    t_machine_level();
    t_illegal_paths();
    t_virtual_paths();
    t_field_isolation();
    t_inval_modes();
    t_faults();
    t_sweep();
    done = 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  initial begin
    wait (done || cycles >= WATCHDOG_CYCLES);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule